// File: doc/BRIEF.md
# Time-Slotted Audio Link Controller

This block is the controller end of a five-wire serial audio link. The codec supplies the bit clock. The controller divides that clock into fixed frames of 256 bit periods. At the start of each frame it raises a frame strobe, and it drives an active-low reset line toward the codec. Each frame carries a 16-bit tag slot followed by twelve 20-bit data slots. Every slot is sent most significant bit first: playback data on the serial output, and capture data on the serial input at the same time.

Software-facing logic sees the link as parallel words. The outgoing tag and twelve outgoing slots are presented at the inputs. They are copied into the frame image at each frame boundary, so the inputs may change at any time without tearing a frame. The incoming tag and slots appear as registered outputs once the last bit of a frame has been received, together with a one-cycle frame-done pulse. A synchronous link-reset request stops the frame engine, silences the link and pulls the codec reset low. When the request is released, a fresh frame starts on the next rising edge.

Top module: `slot_link_ctrl`

## Requirements
- R1: While `rst_n` is low, or on every rising edge after `link_reset_req` has been sampled high: `frame_sync` is 0, `ser_out` is 0, `codec_rst_n` is 0 and `frame_done` is 0. The internal slot position is 0.
- R2: In steady operation `frame_sync` rises exactly once every 256 bit clocks (16 + 12*20).
- R3: `frame_sync` is high for exactly the first 16 bit clocks of each frame, which is the tag slot, and low for the remaining 240.
- R4: `ser_out` changes on the rising edge. Frame bit k (k = 0 at the rising edge that raises `frame_sync`) carries bit 15-k of the tag for k < 16. For k >= 16 it carries bit 19-((k-16) mod 20) of slot s = (k-16)/20 + 1. Slot s is taken from `tx_slots[20*s-1 : 20*(s-1)]`.
- R5: The tag and slot inputs are sampled only at the rising edge that starts a frame. Later changes do not alter the frame in progress.
- R6: `ser_in` is sampled on the falling edge of each bit period. After a frame, `rx_tag` and `rx_slots` hold the received bits in the same layout as R4.
- R7: `frame_done` is high for one bit period. It rises on the falling edge that samples frame bit 255. A frame cut short by a link reset raises no pulse.
- R8: On the first rising edge after `link_reset_req` is sampled low again, `frame_sync` and `codec_rst_n` go high and frame bit 0 (tag MSB) is driven.
- R9: `rx_tag` and `rx_slots` change only on the edge that raises `frame_done`, and hold their value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low block reset |
| link_reset_req | input | 1 | Synchronous request to hold the link and codec in reset |
| tx_tag | input | TAG_W (16) | Outgoing tag word |
| tx_slots | input | N_SLOTS*SLOT_W (240) | Outgoing data slots, slot 1 in the low bits |
| ser_in | input | 1 | Serial capture data from the codec |
| ser_out | output | 1 | Serial playback data to the codec |
| frame_sync | output | 1 | Frame strobe, high during the tag slot |
| codec_rst_n | output | 1 | Active-low reset toward the codec |
| rx_tag | output | TAG_W (16) | Received tag word |
| rx_slots | output | N_SLOTS*SLOT_W (240) | Received data slots, slot 1 in the low bits |
| frame_done | output | 1 | One-cycle pulse when a received frame is complete |

## Verification
The hardest situation to reach from the ports is a link reset that arrives partway through a frame, while the parallel inputs keep changing underneath the serial stream. For that case the bench must show three things:
- the aborted frame produces no done pulse and leaves the captured words untouched;
- the next frame starts cleanly with its tag MSB;
- the frame in flight never picks up a rewritten input.

The bench waits for a chosen slot position and raises the reset request there. During and after that, random input rewrites from a seeded generator land on arbitrary bit periods.

// File: rtl/slot_link_pkg.sv
package slot_link_pkg;
    parameter int TAG_BITS   = 16;
    parameter int SLOT_BITS  = 20;
    parameter int DATA_SLOTS = 12;

    function automatic int frame_bits(input int tag_w, input int slot_w, input int n_slots);
        return tag_w + slot_w * n_slots;
    endfunction
endpackage

// File: rtl/slot_link_seq.sv
module slot_link_seq #(
    parameter int FRAME_LEN = 256,
    parameter int TAG_W     = 16,
    localparam int CNT_W    = $clog2(FRAME_LEN)
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             link_req,
    output logic             run,
    output logic [CNT_W-1:0] pos,
    output logic             frame_start,
    output logic             sync,
    output logic             codec_rst_n
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TAG_LIM  = CNT_W'(TAG_W);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             sync;
        logic             lrst_n;
    } seq_state_t;

    seq_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        st_d        = st_q;
        cnt_next    = '0;
        frame_start = 1'b0;
        if (link_req) begin
            st_d.run    = 1'b0;
            st_d.cnt    = '0;
            st_d.sync   = 1'b0;
            st_d.lrst_n = 1'b0;
        end else begin
            if (!st_q.run || (st_q.cnt == LAST_POS)) begin
                cnt_next    = '0;
                frame_start = 1'b1;
            end else begin
                cnt_next = st_q.cnt + 1'b1;
            end
            st_d.run    = 1'b1;
            st_d.cnt    = cnt_next;
            st_d.sync   = (cnt_next < TAG_LIM);
            st_d.lrst_n = 1'b1;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run         = st_q.run;
    assign pos         = st_q.cnt;
    assign sync        = st_q.sync;
    assign codec_rst_n = st_q.lrst_n;

    AST_HOLD_IDLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        link_req |=> (st_q.cnt == '0 && !st_q.sync && !st_q.run)); // R1
    AST_CODEC_RST_LOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
        link_req |=> !st_q.lrst_n); // R1
    AST_POS_STEP: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (st_q.run && !link_req) |=>
        (st_q.cnt == (($past(st_q.cnt) == LAST_POS) ? '0 : $past(st_q.cnt) + 1'b1))); // R2
    AST_SYNC_IN_TAG: assert property (@(posedge bit_clk) disable iff (!rst_n)
        st_q.sync |-> (st_q.run && st_q.cnt < TAG_LIM)); // R3
    AST_RESTART: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!st_q.run && !link_req) |=> (st_q.run && st_q.cnt == '0 && st_q.sync && st_q.lrst_n)); // R8
endmodule

// File: rtl/slot_link_tx.sv
module slot_link_tx #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12,
    localparam int FRAME_LEN = TAG_W + SLOT_W * N_SLOTS
) (
    input  logic                      bit_clk,
    input  logic                      rst_n,
    input  logic                      link_req,
    input  logic                      run,
    input  logic                      frame_start,
    input  logic [TAG_W-1:0]          tag,
    input  logic [SLOT_W*N_SLOTS-1:0] slots,
    output logic                      sdo
);
    typedef struct packed {
        logic [FRAME_LEN-1:0] shift;
    } tx_state_t;

    tx_state_t st_q, st_d;
    logic [FRAME_LEN-1:0] frame_img;

    always_comb begin
        frame_img = '0;
        frame_img[FRAME_LEN-1 -: TAG_W] = tag;
        for (int i = 0; i < N_SLOTS; i++) begin
            frame_img[FRAME_LEN-1-TAG_W-SLOT_W*i -: SLOT_W] = slots[SLOT_W*i +: SLOT_W];
        end
    end

    always_comb begin
        st_d = st_q;
        if (link_req) begin
            st_d.shift = '0;
        end else if (frame_start) begin
            st_d.shift = frame_img;
        end else if (run) begin
            st_d.shift = {st_q.shift[FRAME_LEN-2:0], 1'b0};
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo = st_q.shift[FRAME_LEN-1];

    AST_TX_QUIET: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !run |-> !sdo); // R1
    AST_TX_LOAD_TAG: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (frame_start && !link_req) |=> (sdo == $past(tag[TAG_W-1]))); // R4
endmodule

// File: rtl/slot_link_rx.sv
module slot_link_rx #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 12,
    localparam int FRAME_LEN = TAG_W + SLOT_W * N_SLOTS,
    localparam int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic                      bit_clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic [CNT_W-1:0]          pos,
    input  logic                      sdi,
    output logic [TAG_W-1:0]          tag,
    output logic [SLOT_W*N_SLOTS-1:0] slots,
    output logic                      done
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [FRAME_LEN-1:0]      shift;
        logic [TAG_W-1:0]          tag;
        logic [SLOT_W*N_SLOTS-1:0] slots;
        logic                      done;
    } rx_state_t;

    rx_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (run) begin
            st_d.shift = {st_q.shift[FRAME_LEN-2:0], sdi};
            if (pos == LAST_POS) begin
                st_d.tag = st_d.shift[FRAME_LEN-1 -: TAG_W];
                for (int i = 0; i < N_SLOTS; i++) begin
                    st_d.slots[SLOT_W*i +: SLOT_W] = st_d.shift[FRAME_LEN-1-TAG_W-SLOT_W*i -: SLOT_W];
                end
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tag   = st_q.tag;
    assign slots = st_q.slots;
    assign done  = st_q.done;

    AST_DONE_AT_END: assert property (@(negedge bit_clk) disable iff (!rst_n)
        st_q.done |-> $past(run && pos == LAST_POS)); // R7
    AST_DONE_SINGLE: assert property (@(negedge bit_clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R7
    AST_RX_TAG_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !st_q.done |-> $stable(st_q.tag)); // R9
    AST_RX_SLOT_HOLD: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !st_q.done |-> $stable(st_q.slots)); // R9
endmodule

// File: rtl/slot_link_ctrl.sv
module slot_link_ctrl #(
    parameter int TAG_W   = slot_link_pkg::TAG_BITS,
    parameter int SLOT_W  = slot_link_pkg::SLOT_BITS,
    parameter int N_SLOTS = slot_link_pkg::DATA_SLOTS
) (
    input  logic                      bit_clk,
    input  logic                      rst_n,
    input  logic                      link_reset_req,
    input  logic [TAG_W-1:0]          tx_tag,
    input  logic [SLOT_W*N_SLOTS-1:0] tx_slots,
    input  logic                      ser_in,
    output logic                      ser_out,
    output logic                      frame_sync,
    output logic                      codec_rst_n,
    output logic [TAG_W-1:0]          rx_tag,
    output logic [SLOT_W*N_SLOTS-1:0] rx_slots,
    output logic                      frame_done
);
    localparam int FRAME_LEN = slot_link_pkg::frame_bits(TAG_W, SLOT_W, N_SLOTS);
    localparam int CNT_W     = $clog2(FRAME_LEN);

    logic             run;
    logic [CNT_W-1:0] pos;
    logic             frame_start;

    slot_link_seq #(.FRAME_LEN(FRAME_LEN), .TAG_W(TAG_W)) u_seq (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .link_req    (link_reset_req),
        .run         (run),
        .pos         (pos),
        .frame_start (frame_start),
        .sync        (frame_sync),
        .codec_rst_n (codec_rst_n)
    );

    slot_link_tx #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_tx (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .link_req    (link_reset_req),
        .run         (run),
        .frame_start (frame_start),
        .tag         (tx_tag),
        .slots       (tx_slots),
        .sdo         (ser_out)
    );

    slot_link_rx #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_rx (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .run     (run),
        .pos     (pos),
        .sdi     (ser_in),
        .tag     (rx_tag),
        .slots   (rx_slots),
        .done    (frame_done)
    );

    AST_RESET_QUIET: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !codec_rst_n |-> (!frame_sync && !ser_out)); // R1
endmodule

// File: tb/slot_link_ctrl_test.sv
`timescale 1ns/1ps
module slot_link_ctrl_test;
    localparam int FL = 256;

    logic         bit_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         link_reset_req = 1'b0;
    logic [15:0]  tx_tag = '0;
    logic [239:0] tx_slots = '0;
    logic         ser_in = 1'b0;
    logic         ser_out, frame_sync, codec_rst_n, frame_done;
    logic [15:0]  rx_tag;
    logic [239:0] rx_slots;

    slot_link_ctrl uut (
        .bit_clk(bit_clk), .rst_n(rst_n), .link_reset_req(link_reset_req),
        .tx_tag(tx_tag), .tx_slots(tx_slots), .ser_in(ser_in),
        .ser_out(ser_out), .frame_sync(frame_sync), .codec_rst_n(codec_rst_n),
        .rx_tag(rx_tag), .rx_slots(rx_slots), .frame_done(frame_done)
    );

    always #2.5 bit_clk = ~bit_clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int pos = -1;
    logic prev_sync = 1'b0;
    logic [FL-1:0] exp_tx = '0, cur_rx = '0, last_rx = '0;
    int tx_bad = 0, sync_bad = 0, done_bad = 0, frame_idx = 0;
    bit mutate = 1'b0;

    task automatic chk(input string req, input bit ok, input logic [FL-1:0] act, input logic [FL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [FL-1:0] pack(input logic [15:0] t, input logic [239:0] s);
        logic [FL-1:0] f = {240'd0, t};
        for (int k = 0; k < 12; k++) f = {f[FL-21:0], s[20*k +: 20]};
        return f;
    endfunction

    function automatic logic [FL-1:0] rand256();
        logic [FL-1:0] v = '0;
        for (int k = 0; k < 8; k++) v = {v[FL-33:0], $urandom};
        return v;
    endfunction

    function automatic logic [FL-1:0] next_rx(input int idx);
        case (idx)
            0: return '1;
            1: return '0;
            2: return {128{2'b10}};
            default: return rand256();
        endcase
    endfunction

    task automatic tick();
        logic [FL-1:0] r;
        @(posedge bit_clk); #1;
        if (frame_sync && !prev_sync) begin
            if (pos >= 0) chk("R2 frame period", pos == FL-1, 256'(pos), 256'(FL-1));
            if (pos == FL-1) begin
                chk("R7 done at frame end", frame_done == 1'b1, 256'(frame_done), 256'd1);
                chk("R6 capture", pack(rx_tag, rx_slots) == cur_rx, pack(rx_tag, rx_slots), cur_rx);
                last_rx = cur_rx;
            end
            pos = 0;
            exp_tx = pack(tx_tag, tx_slots);
            cur_rx = next_rx(frame_idx);
            frame_idx++;
            tx_bad = 0; sync_bad = 0; done_bad = 0;
        end else if (pos >= 0) begin
            pos++;
            if (pos >= FL) begin
                chk("R2 missing frame start", 1'b0, 256'(pos), 256'(FL-1));
                pos = -1;
            end
        end
        prev_sync = frame_sync;
        if (pos >= 0) begin
            if (ser_out !== exp_tx[FL-1-pos]) tx_bad++;
            if (frame_sync !== (pos < 16)) sync_bad++;
            if (pos != 0 && frame_done !== 1'b0) done_bad++;
            if (pos == 128) begin
                r = pack(rx_tag, rx_slots);
                chk("R9 rx hold mid-frame", r == last_rx, r, last_rx);
            end
            if (pos == FL-1) begin
                chk("R4 R5 serial frame bits", tx_bad == 0, 256'(tx_bad), 256'd0);
                chk("R3 sync width", sync_bad == 0, 256'(sync_bad), 256'd0);
                chk("R7 done quiet mid-frame", done_bad == 0, 256'(done_bad), 256'd0);
            end
            ser_in = cur_rx[FL-1-pos];
        end else begin
            ser_in = 1'($urandom);
        end
        if (mutate && ($urandom % 4 == 0)) begin
            tx_tag = 16'($urandom);
            tx_slots = rand256()[239:0];
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        tx_tag = 16'hFFFF;
        tx_slots = '1;
        repeat (4) tick();
        // R1: reset state
        chk("R1 sync in reset", frame_sync == 1'b0, 256'(frame_sync), 256'd0);
        chk("R1 ser_out in reset", ser_out == 1'b0, 256'(ser_out), 256'd0);
        chk("R1 codec reset low", codec_rst_n == 1'b0, 256'(codec_rst_n), 256'd0);
        chk("R1 done low", frame_done == 1'b0, 256'(frame_done), 256'd0);
        chk("R1 rx cleared", pack(rx_tag, rx_slots) == '0, pack(rx_tag, rx_slots), '0);
        rst_n = 1'b1;
        tick();
        chk("R8 start after reset", frame_sync && codec_rst_n && ser_out, 256'({frame_sync, codec_rst_n, ser_out}), 256'd7);
        // R5: rewrite inputs mid-frame; frame 0 must stay all ones
        repeat (40) tick();
        tx_tag = 16'h0000;
        tx_slots = '0;
        while (pos != 60) tick();
        tx_tag = 16'hA5C3;
        for (int k = 0; k < 12; k++) tx_slots[20*k +: 20] = 20'hF0000 | 20'(k + 1);
        repeat (2 * FL) tick();
        mutate = 1'b1;
        repeat (2 * FL) tick();
        // link reset in the middle of a frame
        while (pos != 100) tick();
        link_reset_req = 1'b1;
        pos = -1;
        tick();
        chk("R1 sync after link reset", frame_sync == 1'b0, 256'(frame_sync), 256'd0);
        chk("R1 ser_out after link reset", ser_out == 1'b0, 256'(ser_out), 256'd0);
        chk("R1 codec reset asserted", codec_rst_n == 1'b0, 256'(codec_rst_n), 256'd0);
        begin
            int bad = 0;
            for (int k = 0; k < 8; k++) begin
                tick();
                if (frame_sync || ser_out || codec_rst_n || frame_done) bad++;
            end
            chk("R1 R7 held quiet in link reset", bad == 0, 256'(bad), 256'd0);
        end
        chk("R9 rx held through link reset", pack(rx_tag, rx_slots) == last_rx, pack(rx_tag, rx_slots), last_rx);
        link_reset_req = 1'b0;
        tick();
        chk("R8 restart after link reset", frame_sync && codec_rst_n, 256'({frame_sync, codec_rst_n}), 256'd3);
        chk("R7 no done for aborted frame", frame_done == 1'b0, 256'(frame_done), 256'd0);
        repeat (3 * FL + 4) tick();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule